// File: doc/BRIEF.md
# Downstream Port Power Switch Controller

This block drives the power switches of up to four downstream ports of a self-powered hub. Each port has its own power enable. Hub status logic turns a port on with a one-cycle set strobe and off with a one-cycle clear strobe. The power-enable output is active low, so driving it low closes the external switch.

Every port has an active-low overcurrent sense input, which is resynchronised inside the block. The sense is acted on only while that port is powered. It must stay low for a whole filter window, counted in microsecond ticks, before the block opens that port's switch. A trip cuts only the offending port. It also raises a sticky change flag that the hub status logic acknowledges with a separate strobe.

The microsecond tick is divided down from the system clock. With the default window of 501 ticks, a sustained fault removes power between 500 µs and roughly 501 µs after the sense goes low. A port-count parameter leaves the ports above the populated count permanently off.

Top module: `port_pwr_ctl`

## Requirements
- R1: After reset every `pwr_en_n` bit is 1 (off) and every `oc_chg` bit is 0.
- R2: A `pwr_set` strobe on an active port drives its `pwr_en_n` low on the next clock. A `pwr_clr` strobe drives it high on the next clock. When both strobes arrive in the same cycle, the clear wins.
- R3: While a port is unpowered its `oc_n` input has no effect: no trip occurs and `oc_chg` stays 0. The filter starts from zero when power is switched on.
- R4: The tick fires once every CLK_PER_US clocks. If `oc_n` is held low on a powered port, `pwr_en_n` returns to 1 after OC_US ticks have been counted. Counting starts after a two-flop synchroniser, so the delay falls between (OC_US-1)·CLK_PER_US+3 and OC_US·CLK_PER_US+3 clocks.
- R5: If `oc_n` returns high before the window expires, the filter count is cleared and power stays on. A later low must again last the full window.
- R6: A trip on one port leaves the power and change flag of every other port unchanged.
- R7: A trip sets that port's `oc_chg`. The flag stays 1 until a `chg_clr` strobe for that port, and reads 0 on the clock after the strobe.
- R8: A `pwr_set` strobe after a trip restores power and re-arms the filter with a full window.
- R9: Ports with index at or above PORT_COUNT never drive `pwr_en_n` low and never set `oc_chg`, whatever their inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_set | input | NUM_PORTS | Per-port power-on strobe |
| pwr_clr | input | NUM_PORTS | Per-port power-off strobe |
| chg_clr | input | NUM_PORTS | Per-port acknowledge of the overcurrent change flag |
| oc_n | input | NUM_PORTS | Per-port overcurrent sense, active low, asynchronous |
| pwr_en_n | output | NUM_PORTS | Per-port switch enable, active low |
| oc_chg | output | NUM_PORTS | Per-port sticky overcurrent change flag |

## Verification
The bench builds the block with NUM_PORTS=4, PORT_COUNT=3, CLK_PER_US=4 and OC_US=6. With these values a full filter window takes only about two dozen clocks, so the scenarios can probe both edges of it: a sustained fault, a fault that goes away and comes back, a fault raised while a port is off, and a restore after a trip. Choosing PORT_COUNT below NUM_PORTS leaves the fourth port unpopulated, so the bench can drive all of its inputs and confirm that it stays off.

// File: rtl/port_pwr_pkg.sv
// Package: shared limits and helpers for the port power controller.
// Assumes: no more than four downstream ports exist on the hub.
package port_pwr_pkg;
    localparam int MAX_PORTS = 4;

    // Width of a counter that must hold the value lim.
    function automatic int cnt_w(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction
endpackage

// File: rtl/port_pwr_tick.sv
// Module: divides the system clock down to a single-cycle microsecond pulse.
// Assumes: CLK_PER_US >= 2 clock cycles per microsecond.
module port_pwr_tick #(
    parameter int CLK_PER_US = 48
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = port_pwr_pkg::cnt_w(CLK_PER_US - 1);
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] div_q;

    assign tick = (div_q == LAST);

    // Free-running divider that wraps after CLK_PER_US cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    // R4: ticks are isolated single-cycle pulses.
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/port_pwr_lane.sv
// Module: power switch state, overcurrent filter and change flag of one port.
// Assumes: oc_n is asynchronous (it is synchronised here); strobes last one cycle.
module port_pwr_lane #(
    parameter int  OC_US  = 501,
    parameter bit  ACTIVE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_set,
    input  logic pwr_clr,
    input  logic chg_clr,
    input  logic oc_n,
    output logic pwr_en_n,
    output logic oc_chg
);
    localparam int CW = port_pwr_pkg::cnt_w(OC_US);
    localparam logic [CW-1:0] LAST = CW'(OC_US - 1);

    logic          oc_s1, oc_s2;
    logic          pwr_on;
    logic [CW-1:0] flt_q;
    logic          trip;
    logic          set_ok;
    logic          clr_ok;

    assign set_ok   = ACTIVE && pwr_set;
    assign clr_ok   = pwr_clr || !ACTIVE;
    assign trip     = pwr_on && !oc_s2 && tick && (flt_q == LAST);
    assign pwr_en_n = !pwr_on;

    // Two-flop synchroniser for the sense input; idles at "no fault".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_s1 <= 1'b1;
            oc_s2 <= 1'b1;
        end else begin
            oc_s1 <= oc_n;
            oc_s2 <= oc_s1;
        end
    end

    // Switch state: clear beats set, and set beats a same-cycle trip.
    always_ff @(posedge clk) begin
        if (!rst_n)      pwr_on <= 1'b0;
        else if (clr_ok) pwr_on <= 1'b0;
        else if (set_ok) pwr_on <= 1'b1;
        else if (trip)   pwr_on <= 1'b0;
    end

    // Filter: counts ticks of continuous fault while powered, otherwise holds zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flt_q <= '0;
        else if (!pwr_on || oc_s2 || set_ok || clr_ok || trip)
            flt_q <= '0;
        else if (tick)
            flt_q <= flt_q + 1'b1;
    end

    // Sticky change flag: a trip sets it, an acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)       oc_chg <= 1'b0;
        else if (trip)    oc_chg <= 1'b1;
        else if (chg_clr) oc_chg <= 1'b0;
    end

    // R4: the filter count never passes the window.
    p_flt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q <= LAST);
    // R3: nothing accumulates while the port is unpowered.
    p_idle_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_n && !set_ok) |=> (flt_q == '0));
    // R2: power only comes on after a set strobe.
    p_on_needs_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_n) |-> $past(set_ok));
    // R7: the change flag holds until acknowledged.
    p_chg_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_chg && !chg_clr) |=> oc_chg);
    // R4: a trip opens the switch unless a set strobe overrides it.
    p_trip_cuts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !set_ok) |=> (pwr_en_n && oc_chg));
endmodule

// File: rtl/port_pwr_ctl.sv
// Module: top of the downstream port power controller; one lane per port.
// Assumes: self-powered hub, NUM_PORTS <= 4, 1 <= PORT_COUNT <= NUM_PORTS.
module port_pwr_ctl #(
    parameter int NUM_PORTS  = 4,
    parameter int PORT_COUNT = 4,
    parameter int CLK_PER_US = 48,
    parameter int OC_US      = 501
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] pwr_set,
    input  logic [NUM_PORTS-1:0] pwr_clr,
    input  logic [NUM_PORTS-1:0] chg_clr,
    input  logic [NUM_PORTS-1:0] oc_n,
    output logic [NUM_PORTS-1:0] pwr_en_n,
    output logic [NUM_PORTS-1:0] oc_chg
);
    logic tick;

    initial begin
        assert (NUM_PORTS >= 1 && NUM_PORTS <= port_pwr_pkg::MAX_PORTS);
        assert (PORT_COUNT >= 1 && PORT_COUNT <= NUM_PORTS);
    end

    port_pwr_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        port_pwr_lane #(.OC_US(OC_US), .ACTIVE(p < PORT_COUNT)) u_lane (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .pwr_set(pwr_set[p]), .pwr_clr(pwr_clr[p]), .chg_clr(chg_clr[p]),
            .oc_n(oc_n[p]), .pwr_en_n(pwr_en_n[p]), .oc_chg(oc_chg[p])
        );
        if (p >= PORT_COUNT) begin : g_unused
            // R9: an unpopulated port is never powered and never flags.
            p_unused_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
                pwr_en_n[p] && !oc_chg[p]);
        end
    end
endmodule

// File: tb/sim_port_pwr_ctl.sv
// Bench: directed scenarios for the port power controller, one task each.
module sim_port_pwr_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pwr_set = '0, pwr_clr = '0, chg_clr = '0, oc_n = '1;
    logic [NP-1:0] pwr_en_n, oc_chg;
    int            total = 0, bad = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_pwr_ctl #(.NUM_PORTS(NP), .PORT_COUNT(3), .CLK_PER_US(4), .OC_US(6)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_set(pwr_set), .pwr_clr(pwr_clr),
        .chg_clr(chg_clr), .oc_n(oc_n), .pwr_en_n(pwr_en_n), .oc_chg(oc_chg)
    );

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_set(input logic [NP-1:0] m);
        pwr_set = m; wait_n(1); pwr_set = '0;
    endtask

    task automatic strobe_clr(input logic [NP-1:0] m);
        pwr_clr = m; wait_n(1); pwr_clr = '0;
    endtask

    task automatic strobe_ack(input logic [NP-1:0] m);
        chg_clr = m; wait_n(1); chg_clr = '0;
    endtask

    task automatic t_reset;
        chk("R1 power after reset", pwr_en_n, 4'b1111);
        chk("R1 change after reset", oc_chg, 4'b0000);
    endtask

    task automatic t_set_clr;
        strobe_set(4'b0111);
        chk("R2 set powers ports", pwr_en_n, 4'b1000);
        pwr_set = 4'b0001; pwr_clr = 4'b0001; wait_n(1);
        pwr_set = '0; pwr_clr = '0;
        chk("R2 clear beats set", pwr_en_n, 4'b1001);
        strobe_clr(4'b0110);
        chk("R2 clear removes power", pwr_en_n, 4'b1111);
    endtask

    task automatic t_ignored_when_off;
        oc_n = 4'b1110; wait_n(40);
        chk("R3 no trip while off", oc_chg, 4'b0000);
        chk("R3 still off", pwr_en_n, 4'b1111);
        strobe_set(4'b0001);
        wait_n(19);
        chk("R3 filter fresh at power-on", pwr_en_n, 4'b1110);
        wait_n(10);
        chk("R4 sustained fault trips", pwr_en_n, 4'b1111);
        chk("R7 change flag set", oc_chg, 4'b0001);
        oc_n = '1; wait_n(8);
        chk("R7 flag sticky", oc_chg, 4'b0001);
        strobe_ack(4'b0001);
        chk("R7 ack clears flag", oc_chg, 4'b0000);
    endtask

    task automatic t_trip_window;
        strobe_set(4'b0111);
        oc_n = 4'b1101; wait_n(20);
        chk("R4 on before window", pwr_en_n, 4'b1000);
        wait_n(10);
        chk("R4 off after window", pwr_en_n, 4'b1010);
        chk("R6 only port 1 flagged", oc_chg, 4'b0010);
        oc_n = '1; wait_n(4);
    endtask

    task automatic t_restore;
        strobe_set(4'b0010);
        chk("R8 set restores power", pwr_en_n, 4'b1000);
        oc_n = 4'b1101; wait_n(20);
        chk("R8 full window re-armed", pwr_en_n, 4'b1000);
        wait_n(10);
        chk("R8 trips again", pwr_en_n, 4'b1010);
        oc_n = '1; strobe_ack(4'b0010); wait_n(3);
        strobe_set(4'b0010);
    endtask

    task automatic t_glitch;
        oc_n = 4'b1011; wait_n(12);
        oc_n = '1; wait_n(4);
        oc_n = 4'b1011; wait_n(20);
        chk("R5 short fault forgotten", pwr_en_n, 4'b1000);
        chk("R5 no flag", oc_chg, 4'b0000);
        oc_n = '1; wait_n(4);
    endtask

    task automatic t_unused;
        pwr_set = 4'b1000; oc_n = 4'b0111; wait_n(40);
        pwr_set = '0;
        chk("R9 unused port stays off", pwr_en_n[3], 1'b1);
        chk("R9 unused port no flag", oc_chg, 4'b0000);
        oc_n = '1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_set_clr();
        t_ignored_when_off();
        t_trip_window();
        t_restore();
        t_glitch();
        t_unused();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule